// File: doc/BRIEF.md
# Serial-Configured Clock Fan-Out Gate Controller

This block takes one reference clock and presents seven copies of it. Each copy can be switched on or off by a write-only two-wire serial slave. The slave listens for its fixed device address. It then accepts two filler bytes whose contents are discarded, followed by the configuration bytes in a fixed order. Because the slave has no register pointer, the second configuration byte can only be reached by sending the first one in the same transfer.

SCL and SDA are oversampled by a system clock that runs at least eight times faster than SCL. The acknowledge is returned as an open-drain pull-down enable. Every enable bit is retimed onto the falling edge of the reference clock. As a result, a copy starts or stops only between whole high pulses, and a disabled copy sits low.

Top module: `clkout_enable_ctrl`

## Requirements
- R1: The slave answers only to the address byte 0xD2, which is seven address bits 1101001 followed by a write bit of 0. Any other address, and the read request 0xD3, gets no acknowledge. The bytes that follow such an address are also not acknowledged and change nothing.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start received partway through a byte abandons that byte and treats the next byte as an address. Bytes sent after a stop and before the next start are ignored.
- R3: Bytes arrive MSB first. After each accepted byte, sda_oe_o is asserted from the falling SCL edge that ends bit 8 until the falling edge that ends the ninth pulse. It is low otherwise.
- R4: The two bytes that follow the address are acknowledged, and their values have no effect on the outputs.
- R5: The first configuration byte sets the enables as follows: bit 0 drives output 0, bit 1 drives output 1, bit 4 drives output 2, bit 6 drives output 3 and bit 7 drives output 4. Bits 2, 3 and 5 are ignored.
- R6: The second configuration byte sets the remaining enables: bit 0 drives output 5 and bit 1 drives output 6. Its other bits are ignored. A transfer that stops after the first configuration byte leaves outputs 5 and 6 unchanged.
- R7: Bytes beyond the second configuration byte are acknowledged and then discarded.
- R8: A configuration byte cut short by a stop leaves all enables unchanged.
- R9: After reset, all seven outputs are enabled and follow ref_clk_i.
- R10: An enable value of 1 passes the reference clock to the output, and a value of 0 holds the output low. Every high pulse on an output lasts the full reference high phase, so no shortened pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| clk_o | output | 7 | Gated copies of the reference clock |

## Verification
The hardest cases to reach are transfers that break off at an awkward point. One is a repeated start three bits into the byte after the address. Another is a stop four bits into the first configuration byte. The bench builds these from bit-level tasks that can leave a byte unfinished before issuing the bus condition. It then checks that the enables still hold a pattern written just before. A 128-step sweep covers every enable combination, with the ignored bits set to both values. A monitor on the reference clock checks that each output high phase is stable from edge to edge while the enables change.

// File: rtl/clkout_ctrl_pkg.sv
`timescale 1ns/1ps
package clkout_ctrl_pkg;
  localparam int NUM_OUT     = 7;
  localparam int BYTE_W      = 8;
  localparam int DUMMY_BYTES = 2;
  localparam int DATA_BYTES  = 2;
  localparam int IDX_W       = 3;
  localparam logic [BYTE_W-1:0] DEV_ADDR = 8'hD2;

  typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_ACK, RX_SKIP} rx_phase_e;

  // which configuration byte carries the enable of output k
  function automatic int map_byte(input int k);
    return (k < 5) ? 0 : 1;
  endfunction

  // bit position of output k inside its byte
  function automatic int map_bit(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 4;
      3: return 6;
      4: return 7;
      5: return 0;
      6: return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/line_sync.sv
`timescale 1ns/1ps
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[MSB];
      sda_q  <= sda_sh[MSB];
    end
  end

  assign scl_s      = scl_sh[MSB];
  assign sda_s      = sda_sh[MSB];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/write_rx.sv
`timescale 1ns/1ps
module write_rx
  import clkout_ctrl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sda_i,
  input  logic                  scl_rise_i,
  input  logic                  scl_fall_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  output logic                  ack_o,
  output logic [DATA_BYTES-1:0] wr_sel_o,
  output logic [BYTE_W-1:0]     wr_data_o
);
  localparam int FIRST_DATA = 1 + DUMMY_BYTES;
  localparam int LAST_IDX   = FIRST_DATA + DATA_BYTES;
  localparam int CNT_W      = $clog2(BYTE_W + 1);

  rx_phase_e         phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] shreg;
  logic              ack_hi;
  logic [DATA_BYTES-1:0] data_hit;

  always_comb begin
    for (int j = 0; j < DATA_BYTES; j++)
      data_hit[j] = (byte_idx == IDX_W'(FIRST_DATA + j));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase     <= RX_IDLE;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      shreg     <= '0;
      ack_hi    <= 1'b0;
      wr_sel_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_sel_o <= '0;
      if (start_i) begin
        phase    <= RX_DATA;
        bit_cnt  <= '0;
        byte_idx <= '0;
      end else if (stop_i) begin
        phase <= RX_IDLE;
      end else begin
        case (phase)
          RX_DATA: begin
            if (scl_rise_i) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i && bit_cnt == CNT_W'(BYTE_W)) begin
              if (byte_idx == '0 && shreg != DEV_ADDR) begin
                phase <= RX_SKIP;
              end else begin
                phase     <= RX_ACK;
                ack_hi    <= 1'b0;
                wr_sel_o  <= data_hit;
                wr_data_o <= shreg;
              end
            end
          end
          RX_ACK: begin
            if (scl_rise_i) begin
              ack_hi <= 1'b1;
            end else if (scl_fall_i && ack_hi) begin
              phase   <= RX_DATA;
              bit_cnt <= '0;
              if (byte_idx != IDX_W'(LAST_IDX)) byte_idx <= byte_idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_o = (phase == RX_ACK);

  assert_start_rearm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (phase == RX_DATA && bit_cnt == '0 && byte_idx == '0));
  assert_stop_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (phase == RX_IDLE && !ack_o));
  assert_ack_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(scl_fall_i));
  assert_idx_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_idx <= IDX_W'(LAST_IDX));
  assert_write_whole_byte_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_o != '0) |-> $past(bit_cnt == CNT_W'(BYTE_W)));
endmodule

// File: rtl/clk_en_regs.sv
`timescale 1ns/1ps
module clk_en_regs
  import clkout_ctrl_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DATA_BYTES-1:0] wr_sel_i,
  input  logic [BYTE_W-1:0]     wr_data_i,
  output logic [NUM_OUT-1:0]    en_o
);
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_en
    localparam int BSEL = map_byte(k);
    localparam int BPOS = map_bit(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             en_o[k] <= 1'b1;
      else if (wr_sel_i[BSEL]) en_o[k] <= wr_data_i[BPOS];
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i == '0) |=> $stable(en_o));
  assert_byte0_map_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel_i[0] |=> (en_o[2] == $past(wr_data_i[4]) && en_o[4] == $past(wr_data_i[7])));
  assert_byte1_map_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i == 2'b01) |=> $stable(en_o[6:5]));
endmodule

// File: rtl/clk_gate_bank.sv
`timescale 1ns/1ps
module clk_gate_bank #(
  parameter int N = 7
) (
  input  logic         ref_clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] clk_o
);
  logic [N-1:0] en_q;

  for (genvar k = 0; k < N; k++) begin : g_gate
    // enable changes only while the reference is low
    always_ff @(negedge ref_clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[k] <= 1'b1;
      else         en_q[k] <= en_i[k];
    end
    assign clk_o[k] = ref_clk_i & en_q[k];
  end
endmodule

// File: rtl/clkout_enable_ctrl.sv
`timescale 1ns/1ps
module clkout_enable_ctrl
  import clkout_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [NUM_OUT-1:0] clk_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DATA_BYTES-1:0] wr_sel;
  logic [BYTE_W-1:0]     wr_data;
  logic [NUM_OUT-1:0]    en_cfg;

  line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  write_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .ack_o(sda_oe_o), .wr_sel_o(wr_sel), .wr_data_o(wr_data)
  );

  clk_en_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .en_o(en_cfg)
  );

  clk_gate_bank #(.N(NUM_OUT)) u_gate (
    .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .en_i(en_cfg), .clk_o(clk_o)
  );
endmodule

// File: tb/clkout_enable_ctrl_test.sv
`timescale 1ns/1ps
module clkout_enable_ctrl_test;
  localparam int H = 5;

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [6:0] clk_o;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, runt_err = 0;
  logic mon_on = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;
  always #7  ref_clk = ~ref_clk;

  clkout_enable_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe), .clk_o(clk_o)
  );

  // R10: each high phase must be stable edge to edge, low phase all zero
  always @(posedge ref_clk) if (mon_on) begin
    logic [6:0] snap;
    #1 snap = clk_o;
    #5 if (clk_o !== snap) runt_err++;
  end
  always @(negedge ref_clk) if (mon_on) begin
    #1 if (clk_o !== 7'h0) runt_err++;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq; repeat (H) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1;
    repeat (2) @(negedge clk);
    ack = sda_oe;
    repeat (H - 2) @(negedge clk);
    scl_m = 1'b0; wq();
    rel = !sda_oe;
  endtask

  function automatic logic [7:0] enc0(input logic [6:0] e, input logic f);
    return {e[4], e[3], f, e[2], f, f, e[1], e[0]};
  endfunction
  function automatic logic [7:0] enc1(input logic [6:0] e, input logic f);
    return {f, ~f, f, f, ~f, f, e[6], e[5]};
  endfunction

  // full write: address, two filler bytes, n_data data bytes; acks ANDed
  task automatic cfg_write(input logic [6:0] e, input logic f, input int n_data,
                           output logic all_ack, output logic all_rel);
    logic a, r;
    all_ack = 1'b1; all_rel = 1'b1;
    bus_start();
    send_byte(8'hD2, a, r);               all_ack &= a; all_rel &= r;
    send_byte({f, 7'h35}, a, r);          all_ack &= a; all_rel &= r;
    send_byte({7'h4C, ~f}, a, r);         all_ack &= a; all_rel &= r;
    for (int d = 0; d < n_data; d++) begin
      send_byte(d == 0 ? enc0(e, f) : (d == 1 ? enc1(e, f) : {8{d[0]}}), a, r);
      all_ack &= a; all_rel &= r;
    end
    bus_stop();
  endtask

  task automatic check_out(input logic [6:0] exp, input string tag);
    logic [6:0] hi, lo;
    repeat (2) @(posedge ref_clk);
    @(posedge ref_clk); #3 hi = clk_o;
    @(negedge ref_clk); #3 lo = clk_o;
    chk(hi === exp && lo === 7'h0, tag, {hi, lo}, {exp, 7'h0});
  endtask

  initial begin
    logic a, r, ok_ack, ok_rel;
    logic [6:0] cur;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R9 reset state
    check_out(7'h7F, "R9 reset enables");
    chk(sda_oe === 1'b0, "R9 sda released", sda_oe, 0);

    // R5 R6 R3 R4 R10: every enable combination, ignored bits at both values
    for (int i = 0; i < 128; i++) begin
      cfg_write(7'(i), i[0] ^ i[3], 2, ok_ack, ok_rel);
      chk(ok_ack === 1'b1, "R3 R4 acks in sweep", ok_ack, 1);
      chk(ok_rel === 1'b1, "R3 release after ninth pulse", ok_rel, 1);
      check_out(7'(i), "R5 R6 R10 sweep outputs");
    end

    cur = 7'h2A;
    cfg_write(cur, 1'b0, 2, ok_ack, ok_rel);
    check_out(cur, "R5 R6 preset");

    // R1 wrong address, and following bytes
    bus_start();
    send_byte(8'hD4, a, r);
    chk(a === 1'b0, "R1 wrong address no ack", a, 0);
    send_byte(8'h00, a, r);
    chk(a === 1'b0, "R1 bytes after wrong address no ack", a, 0);
    send_byte(8'h00, a, r); send_byte(8'h00, a, r); send_byte(8'h00, a, r);
    bus_stop();
    check_out(cur, "R1 wrong address no effect");

    // R1 read request
    bus_start();
    send_byte(8'hD3, a, r);
    chk(a === 1'b0, "R1 read request no ack", a, 0);
    bus_stop();
    check_out(cur, "R1 read request no effect");

    // R6 only first data byte
    cfg_write(7'h15, 1'b1, 1, ok_ack, ok_rel);
    cur = {cur[6:5], 5'h15};
    check_out(cur, "R6 byte1 untouched without it");

    // R7 extra bytes acked and discarded
    cfg_write(7'h4B, 1'b0, 4, ok_ack, ok_rel);
    chk(ok_ack === 1'b1, "R7 extra bytes acked", ok_ack, 1);
    cur = 7'h4B;
    check_out(cur, "R7 extra bytes discarded");

    // R8 partial first data byte then stop
    bus_start();
    send_byte(8'hD2, a, r); send_byte(8'h00, a, r); send_byte(8'h00, a, r);
    for (int b = 0; b < 4; b++) send_bit(1'b0);
    bus_stop();
    check_out(cur, "R8 partial byte no write");

    // R2 repeated start mid-byte restarts address matching
    bus_start();
    send_byte(8'hD2, a, r);
    for (int b = 0; b < 3; b++) send_bit(1'b1);
    bus_start();
    send_byte(8'hD2, a, r);
    chk(a === 1'b1, "R2 address after mid-byte start acked", a, 1);
    send_byte(8'h11, a, r); send_byte(8'h22, a, r);
    send_byte(enc0(7'h33, 1'b1), a, r); send_byte(enc1(7'h33, 1'b1), a, r);
    bus_stop();
    cur = 7'h33;
    check_out(cur, "R2 mid-byte start then write");

    // R2 bytes after stop without start are ignored
    send_byte(8'hD2, a, r);
    chk(a === 1'b0, "R2 no ack without start", a, 0);
    send_byte(8'h00, a, r); send_byte(8'h00, a, r); send_byte(8'h00, a, r);
    check_out(cur, "R2 no effect without start");
    bus_stop();

    // R4 filler contents irrelevant: same data, different fillers
    bus_start();
    send_byte(8'hD2, a, r); send_byte(8'hFF, a, r);
    chk(a === 1'b1, "R4 filler acked", a, 1);
    send_byte(8'h00, a, r);
    send_byte(enc0(7'h0C, 1'b0), a, r); send_byte(enc1(7'h0C, 1'b0), a, r);
    bus_stop();
    check_out(7'h0C, "R4 filler no effect");

    chk(runt_err == 0, "R10 no shortened pulse", runt_err, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule